// File: doc/BRIEF.md
# Dual-Channel Serial Converter Load Interface

This block is the digital front end of a two-channel, 12-bit bipolar voltage-output converter. A host writes to it over a three-wire serial link: a serial clock, an active-low frame strobe and a data line. All three wires are resampled into the system clock domain. Bits are then shifted, most significant first, into a 16-bit frame register on each rising serial-clock edge that arrives while the strobe is low. When the strobe goes high again, the frame is decoded. One bit picks the destination channel. Another bit sets or clears a shutdown flag. The low twelve bits, read as two's complement, are copied into that channel's holding register.

Each channel also drives an offset-binary code for its analog decoder. This code is the holding register with its top bit inverted, so negative full scale becomes all zeros and positive full scale becomes all ones. Reset clears the frame register, parks both channels at the bipolar-zero code and clears shutdown.

A small state machine tracks the frame. It has three states: `ST_IDLE` (strobe high, nothing pending), `ST_SHIFT` (strobe low, frame open) and `ST_COMMIT` (a single cycle in which the holding registers load). It has five transitions:
- `ST_IDLE -> ST_SHIFT` when the synchronised strobe reads low.
- `ST_SHIFT -> ST_COMMIT` when the strobe reads high.
- `ST_COMMIT -> ST_IDLE` when the strobe is still high.
- `ST_COMMIT -> ST_SHIFT` when a new frame has already opened.
- Every state stays put otherwise.

Top module: `dac_serial_front`

## Requirements
- R1: During reset and right after it, both two's-complement outputs read 0x000, both offset-binary outputs read 0x800 and `shutdown` is 0. The frame register is cleared to zero.
- R2: While `fsync_n` is low, each rising edge of `sclk` shifts `sdi` into the frame register, most significant bit first. In a full 16-bit frame, bit 15 is the channel select (0 = A, 1 = B), bit 13 is shutdown and bits 11..0 are the data code.
- R3: At the close of a frame, the addressed channel's holding register takes frame bits 11..0. The other channel's register keeps its value.
- R4: Rising `sclk` edges while `fsync_n` is high leave the frame register unchanged. A following frame with no clock edges therefore re-commits the previous frame's contents.
- R5: `shutdown` takes frame bit 13 at each commit and holds it between commits.
- R6: Each offset-binary output equals its channel's two's-complement code with bit 11 inverted: 0x7FF gives 0xFFF, 0x000 gives 0x800, 0xFFF gives 0x7FF, 0x801 gives 0x001 and 0x800 gives 0x000.
- R7: A frame shorter than 16 bits still commits. The bits received fill the low end of the frame register, and the bits shifted up from earlier contents supply the select and shutdown positions.
- R8: The holding registers and `shutdown` change exactly four system-clock rising edges after `fsync_n` rises: two synchroniser stages, the state transition and the register load. They never change at any other time.
- R9: Frame bits 14 and 12 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least six times faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| fsync_n | input | 1 | Active-low frame strobe, asynchronous |
| sdi | input | 1 | Serial data, asynchronous |
| code_a_tc | output | 12 | Channel A holding register, two's complement |
| code_b_tc | output | 12 | Channel B holding register, two's complement |
| dec_a_ob | output | 12 | Channel A offset-binary decoder code |
| dec_b_ob | output | 12 | Channel B offset-binary decoder code |
| shutdown | output | 1 | Latched shutdown request, active high |

## Verification
The hardest situation to create from the ports is a commit whose select and shutdown bits did not come from the current frame. This needs either a short frame, or serial-clock activity between frames that must be ignored. The stimulus builds up a known frame register with a full frame. It then toggles the serial clock with the strobe high, closes an empty frame, and finally sends a six-bit frame. A behavioural shift model in the bench predicts which old bits land in positions 15 and 13. Every clock, the outputs are compared against that model, so a commit that comes one cycle early or late is caught as well.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
    localparam int DATA_W      = 12;
    localparam int FRAME_W     = 16;
    localparam int SEL_POS     = 15;
    localparam int SD_POS      = 13;
    localparam int N_CH        = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } frame_state_t;
endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/dac_frame_fsm.sv
module dac_frame_fsm
    import dac_if_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          fsync_n_s,
    input  logic          sdi_s,
    output logic [FW-1:0] frame_word,
    output logic          commit
);
    frame_state_t state_q, state_d;
    logic         sclk_q;
    logic         sclk_rise;

    // Edge detector on the synchronised serial clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end
    assign sclk_rise = sclk_s & ~sclk_q;

    // Frame register: shifts only while the strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_word <= '0;
        end else if (sclk_rise && !fsync_n_s) begin
            frame_word <= {frame_word[FW-2:0], sdi_s};
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!fsync_n_s) state_d = ST_SHIFT;
            ST_SHIFT:  if (fsync_n_s)  state_d = ST_COMMIT;
            ST_COMMIT: state_d = fsync_n_s ? ST_IDLE : ST_SHIFT;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        commit = (state_q == ST_COMMIT);
    end
endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
    import dac_if_pkg::*;
#(
    parameter int NCH = N_CH,
    parameter int DW  = DATA_W,
    parameter int FW  = FRAME_W,
    parameter int SP  = SEL_POS,
    parameter int DP  = SD_POS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [FW-1:0]           frame_word,
    output logic [NCH-1:0][DW-1:0]  code_tc,
    output logic [NCH-1:0][DW-1:0]  code_ob,
    output logic                    shutdown
);
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [SEL_W-1:0] sel;
    logic [DW-1:0]    data;

    assign sel  = frame_word[SP -: SEL_W];
    assign data = frame_word[DW-1:0];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_tc[ch] <= '0;
            end else if (commit && (sel == SEL_W'(ch))) begin
                code_tc[ch] <= data;
            end
        end
        assign code_ob[ch] = {~code_tc[ch][DW-1], code_tc[ch][DW-2:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      shutdown <= 1'b0;
        else if (commit) shutdown <= frame_word[DP];
    end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
    import dac_if_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              fsync_n,
    input  logic              sdi,
    output logic [DATA_W-1:0] code_a_tc,
    output logic [DATA_W-1:0] code_b_tc,
    output logic [DATA_W-1:0] dec_a_ob,
    output logic [DATA_W-1:0] dec_b_ob,
    output logic              shutdown
);
    logic [2:0]                   pins_s;
    logic                         sclk_s;
    logic                         fsync_n_s;
    logic                         sdi_s;
    logic [FRAME_W-1:0]           frame_word;
    logic                         commit;
    logic [N_CH-1:0][DATA_W-1:0]  bank_tc;
    logic [N_CH-1:0][DATA_W-1:0]  bank_ob;

    // Bit order: {sdi, fsync_n, sclk}; strobe idles high
    dac_in_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sdi, fsync_n, sclk}),
        .d_sync(pins_s)
    );

    assign sclk_s    = pins_s[0];
    assign fsync_n_s = pins_s[1];
    assign sdi_s     = pins_s[2];

    dac_frame_fsm #(.FW(FRAME_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .fsync_n_s (fsync_n_s),
        .sdi_s     (sdi_s),
        .frame_word(frame_word),
        .commit    (commit)
    );

    dac_chan_bank #(
        .NCH(N_CH),
        .DW (DATA_W),
        .FW (FRAME_W),
        .SP (SEL_POS),
        .DP (SD_POS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .frame_word(frame_word),
        .code_tc   (bank_tc),
        .code_ob   (bank_ob),
        .shutdown  (shutdown)
    );

    assign code_a_tc = bank_tc[0];
    assign code_b_tc = bank_tc[1];
    assign dec_a_ob  = bank_ob[0];
    assign dec_b_ob  = bank_ob[1];
endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        commit,
    input logic        fsync_n_s,
    input logic [15:0] frame_word,
    input logic [11:0] code_a,
    input logic [11:0] code_b,
    input logic        shutdown
);
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (code_a == 12'h000 && code_b == 12'h000 && !shutdown));

    p_no_shift_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_n_s |=> $stable(frame_word));

    p_load_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !frame_word[15]) |=> (code_a == $past(frame_word[11:0])));

    p_load_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame_word[15]) |=> (code_b == $past(frame_word[11:0])));

    p_hold_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && !frame_word[15]) |=> $stable(code_a));

    p_hold_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && frame_word[15]) |=> $stable(code_b));

    p_sd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(shutdown));

    p_commit_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

bind dac_serial_front dac_serial_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .fsync_n_s (fsync_n_s),
    .frame_word(frame_word),
    .code_a    (code_a_tc),
    .code_b    (code_b_tc),
    .shutdown  (shutdown)
);

// File: tb/tb_dac_serial_front.sv
`timescale 1ns/1ps
module tb_dac_serial_front;
    logic        clk = 1'b0;
    logic        rst_n, sclk, fsync_n, sdi;
    logic [11:0] code_a_tc, code_b_tc, dec_a_ob, dec_b_ob;
    logic        shutdown;

    always #10 clk = ~clk;

    dac_serial_front dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n), .sdi(sdi),
        .code_a_tc(code_a_tc), .code_b_tc(code_b_tc),
        .dec_a_ob(dec_a_ob), .dec_b_ob(dec_b_ob), .shutdown(shutdown)
    );

    int          vectors     = 0;
    int          miscompares = 0;
    bit          run_cmp     = 0;
    bit          done        = 0;
    string       phase       = "R1 reset";
    logic [15:0] m_sr;
    logic [11:0] e_a, e_b;
    logic        e_sd;

    task automatic cmp(input string req, input string nm, input logic [11:0] act, input logic [11:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string req);
        vectors++;
        cmp(req, "code_a_tc", code_a_tc, e_a);
        cmp(req, "code_b_tc", code_b_tc, e_b);
        cmp({req, " R6"}, "dec_a_ob", dec_a_ob, e_a ^ 12'h800);
        cmp({req, " R6"}, "dec_b_ob", dec_b_ob, e_b ^ 12'h800);
        cmp({req, " R5"}, "shutdown", {11'd0, shutdown}, {11'd0, e_sd});
    endtask

    // Every-clock comparison, a quarter period after the rising edge
    always @(posedge clk) begin
        #5;
        if (run_cmp && !done) compare_all(phase);
    end

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic sclk_bit(input logic b);
        @(negedge clk); sdi = b; sclk = 1'b0;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        if (!fsync_n) m_sr = {m_sr[14:0], b};
        repeat (3) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic open_frame();
        @(negedge clk); fsync_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // R8: commit visible after the fourth rising edge after the strobe rises
    task automatic close_frame();
        repeat (3) @(negedge clk);
        fsync_n = 1'b1;
        repeat (4) @(posedge clk);
        if (m_sr[15]) e_b = m_sr[11:0];
        else          e_a = m_sr[11:0];
        e_sd = m_sr[13];
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input logic [15:0] w, input int nbits);
        open_frame();
        for (int i = nbits - 1; i >= 0; i--) sclk_bit(w[i]);
        close_frame();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; sclk = 1'b0; fsync_n = 1'b1; sdi = 1'b0;
        m_sr = 16'h0; e_a = 12'h000; e_b = 12'h000; e_sd = 1'b0;
        @(posedge clk);
        run_cmp = 1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        phase = "R2 R3 R8 load A +FS";
        send_frame(16'h07FF, 16);
        phase = "R3 R8 load B -FS";
        send_frame(16'h8800, 16);
        phase = "R3 R6 load A minus one";
        send_frame(16'h0FFF, 16);
        phase = "R3 R6 load B -FS+1";
        send_frame(16'h8801, 16);

        phase = "R5 shutdown set";
        send_frame(16'h2123, 16);
        phase = "R4 R5 stray edges with strobe high";
        for (int k = 0; k < 5; k++) sclk_bit(1'b1);
        phase = "R4 empty frame recommits";
        send_frame(16'h0000, 0);
        phase = "R5 shutdown clear";
        send_frame(16'h8456, 16);

        phase = "R9 ignored bits 14 and 12";
        send_frame(16'h5ABC, 16);
        phase = "R9 ignored bits on B";
        send_frame(16'hD3C5, 16);

        phase = "R7 short frame";
        send_frame(16'h002A, 6);
        phase = "R7 short frame two";
        send_frame(16'h0155, 9);

        phase = "R1 reset mid-run";
        @(negedge clk);
        rst_n = 1'b0;
        m_sr = 16'h0; e_a = 12'h000; e_b = 12'h000; e_sd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        phase = "R1 R4 empty frame after reset";
        send_frame(16'h0000, 0);
        phase = "R2 R3 final load A zero";
        send_frame(16'h0000, 16);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule